// File: doc/BRIEF.md
# Parallelism-Aware Power-Budget Throttle

This controller sets the core enables and the per-core clock operating point of a four-core cluster from the number of runnable threads. Cluster power is energy per instruction times the instruction rate, and it has to stay inside a fixed budget. To do that, the controller picks the core count and the operating point together. When one thread or none is runnable, a single core runs fast. When several threads are runnable, more cores run at the slow point.

There are two parallel policies. In static mode a parallel phase always gets three slow cores. In dynamic mode a parallel phase gets one slow core per runnable thread, up to four. Each operating point has a power weight, and no requested configuration may exceed the budget input. A new configuration is requested only after it has been the target for a programmable number of cycles. The request then waits for the voltage/clock regulator to acknowledge it. All pins are plain control and status pins; there is no stream interface and so no back-pressure.

Top module: `pbt_throttle`

## Requirements
- R1: After reset, every `core_op` field is 00, `core_en` is 0000 and `busy` is 0.
- R2: When `thread_cnt` is 0 or 1 and `budget` is at least 5, the configuration is core 0 at code 10 (2 GHz) and cores 1 to 3 at code 00 (off). Core i uses `core_op[2i+1:2i]`.
- R3: When `thread_cnt` is 2 or more and `dyn_mode` is 0, cores 0 to 2 run at code 01 (1.25 GHz) and core 3 is off, for any thread count (budget at least 6).
- R4: When `thread_cnt` is 2 or more and `dyn_mode` is 1, the lowest min(`thread_cnt`, 4) cores run at code 01 and the rest are off (budget permitting).
- R5: The weights are 2 units for code 01 and 5 units for code 10, and a requested configuration never exceeds `budget`. If the budget is short, parallel phases drop cores from the highest index down to floor(`budget`/2). A sequential phase falls back to core 0 at 01 when the budget is 2 to 4, and to all cores off when it is below 2.
- R6: A new target causes a request only when it is unchanged for `settle_cycles`+1 consecutive rising edges. `busy` rises on the (`settle_cycles`+2)-th rising edge after the input change. A shorter excursion that returns to the last requested configuration causes no request.
- R7: A request sets `busy`, and `core_op`/`core_en` keep their old values until `vreg_ack` is sampled high while `busy` is set.
- R8: Requests that arrive while `busy` is set replace each other. The acknowledge applies only the most recent one and clears `busy`.
- R9: `vreg_ack` while `busy` is 0 has no effect on the outputs or on `busy`.
- R10: If a new request and the acknowledge fall in the same cycle, the new request is applied at that edge and `busy` clears.
- R11: No `core_op` field ever carries code 11, and `core_en[i]` is 1 exactly when core i's field is not 00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| thread_cnt | input | 3 | Runnable-thread count |
| dyn_mode | input | 1 | 1 = dynamic parallel policy, 0 = static |
| budget | input | 5 | Power budget in weight units |
| settle_cycles | input | 8 | Extra cycles a target must stay unchanged before a request |
| vreg_ack | input | 1 | Regulator acknowledge of a pending transition |
| core_en | output | 4 | Per-core enable |
| core_op | output | 8 | 2-bit operating-point code per core |
| busy | output | 1 | Transition pending at the regulator |

## Verification
A newly settled request and the regulator acknowledge can land in the same clock cycle. The bench provokes this with `busy` already set. It then changes the thread count and raises `vreg_ack` exactly in the cycle where the stability window completes. The result is judged correct if the newer configuration appears at once and `busy` drops. Neither the older pending configuration nor a leftover busy state is acceptable.

// File: rtl/pbt_pkg.sv
package pbt_pkg;
  localparam int NCORE  = 4;
  localparam int OPW    = 2;
  localparam int CFG_W  = NCORE * OPW;
  localparam int W_LOW  = 2;
  localparam int W_HIGH = 5;

  typedef enum logic [OPW-1:0] {
    OP_OFF  = 2'b00,
    OP_LOW  = 2'b01,
    OP_HIGH = 2'b10
  } op_e;

  function automatic int cfg_weight(input logic [CFG_W-1:0] cfg);
    int sum;
    sum = 0;
    for (int i = 0; i < NCORE; i++) begin
      if (cfg[OPW*i +: OPW] == OP_LOW)  sum += W_LOW;
      if (cfg[OPW*i +: OPW] == OP_HIGH) sum += W_HIGH;
    end
    return sum;
  endfunction
endpackage

// File: rtl/pbt_planner.sv
module pbt_planner
  import pbt_pkg::*;
#(
  parameter int TCNT_W   = 3,
  parameter int BUD_W    = 5,
  parameter int STATIC_N = 3
) (
  input  logic [TCNT_W-1:0] thread_cnt,
  input  logic              dyn_mode,
  input  logic [BUD_W-1:0]  budget,
  output logic [CFG_W-1:0]  target
);
  int cap;
  int want;
  int ncores;

  always_comb begin
    target = '0;
    cap    = int'(budget) / W_LOW;
    if (cap > NCORE) cap = NCORE;
    want   = 0;
    ncores = 0;
    if (int'(thread_cnt) <= 1) begin
      if (int'(budget) >= W_HIGH)      target[OPW-1:0] = OP_HIGH;
      else if (int'(budget) >= W_LOW)  target[OPW-1:0] = OP_LOW;
    end else begin
      if (dyn_mode) want = (int'(thread_cnt) > NCORE) ? NCORE : int'(thread_cnt);
      else          want = STATIC_N;
      ncores = (want < cap) ? want : cap;
      for (int i = 0; i < NCORE; i++)
        if (i < ncores) target[OPW*i +: OPW] = OP_LOW;
    end
  end
endmodule

// File: rtl/pbt_settle.sv
module pbt_settle
  import pbt_pkg::*;
#(
  parameter int SET_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CFG_W-1:0] target,
  input  logic [SET_W-1:0] settle_cycles,
  output logic             req_valid,
  output logic [CFG_W-1:0] req_cfg
);
  logic [CFG_W-1:0] cand;
  logic [CFG_W-1:0] last_req;
  logic [SET_W-1:0] stable_cnt;

  assign req_valid = (target == cand) && (stable_cnt >= settle_cycles) && (cand != last_req);
  assign req_cfg   = cand;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cand       <= '0;
      last_req   <= '0;
      stable_cnt <= '0;
    end else begin
      if (target != cand) begin
        cand       <= target;
        stable_cnt <= '0;
      end else if (stable_cnt < settle_cycles) begin
        stable_cnt <= stable_cnt + 1'b1;
      end
      if (req_valid) last_req <= cand;
    end
  end
endmodule

// File: rtl/pbt_xfer.sv
module pbt_xfer
  import pbt_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic [CFG_W-1:0] req_cfg,
  input  logic             vreg_ack,
  output logic [CFG_W-1:0] applied,
  output logic             busy
);
  logic [CFG_W-1:0] pending;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      applied <= '0;
      pending <= '0;
      busy    <= 1'b0;
    end else if (busy && vreg_ack) begin
      applied <= req_valid ? req_cfg : pending;
      busy    <= 1'b0;
    end else if (req_valid) begin
      pending <= req_cfg;
      busy    <= 1'b1;
    end
  end
endmodule

// File: rtl/pbt_throttle.sv
module pbt_throttle
  import pbt_pkg::*;
#(
  parameter int TCNT_W   = 3,
  parameter int BUD_W    = 5,
  parameter int SET_W    = 8,
  parameter int STATIC_N = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [TCNT_W-1:0] thread_cnt,
  input  logic              dyn_mode,
  input  logic [BUD_W-1:0]  budget,
  input  logic [SET_W-1:0]  settle_cycles,
  input  logic              vreg_ack,
  output logic [NCORE-1:0]  core_en,
  output logic [CFG_W-1:0]  core_op,
  output logic              busy
);
  logic [CFG_W-1:0] target;
  logic             req_valid;
  logic [CFG_W-1:0] req_cfg;

  pbt_planner #(.TCNT_W(TCNT_W), .BUD_W(BUD_W), .STATIC_N(STATIC_N)) u_plan (
    .thread_cnt(thread_cnt), .dyn_mode(dyn_mode), .budget(budget), .target(target)
  );

  pbt_settle #(.SET_W(SET_W)) u_settle (
    .clk(clk), .rst_n(rst_n), .target(target), .settle_cycles(settle_cycles),
    .req_valid(req_valid), .req_cfg(req_cfg)
  );

  pbt_xfer u_xfer (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_cfg(req_cfg),
    .vreg_ack(vreg_ack), .applied(core_op), .busy(busy)
  );

  for (genvar g = 0; g < NCORE; g++) begin : g_en
    assign core_en[g] = |core_op[OPW*g +: OPW];
  end
endmodule

// File: rtl/pbt_checker.sv
module pbt_checker
  import pbt_pkg::*;
#(
  parameter int TCNT_W = 3,
  parameter int BUD_W  = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic [TCNT_W-1:0] thread_cnt,
  input logic [BUD_W-1:0]  budget,
  input logic              vreg_ack,
  input logic              req_valid,
  input logic [CFG_W-1:0]  req_cfg,
  input logic [CFG_W-1:0]  core_op,
  input logic              busy
);
  function automatic logic has_bad_code(input logic [CFG_W-1:0] c);
    logic bad;
    bad = 1'b0;
    for (int i = 0; i < NCORE; i++) if (c[OPW*i +: OPW] == 2'b11) bad = 1'b1;
    return bad;
  endfunction

  function automatic int active_cores(input logic [CFG_W-1:0] c);
    int n;
    n = 0;
    for (int i = 0; i < NCORE; i++) if (c[OPW*i +: OPW] != OP_OFF) n++;
    return n;
  endfunction

  AST_REQ_IN_BUDGET: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> cfg_weight(req_cfg) <= int'(budget)); // R5
  AST_SEQ_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && int'(thread_cnt) <= 1) |-> active_cores(req_cfg) <= 1); // R2
  AST_HOLD_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !vreg_ack) |=> $stable(core_op)); // R7
  AST_BUSY_FROM_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(req_valid)); // R7
  AST_IDLE_ACK_NOP: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |=> $stable(core_op)); // R9
  AST_ACK_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && vreg_ack) |=> !busy); // R10
  AST_LEGAL_CODE: assert property (@(posedge clk) disable iff (!rst_n)
    !has_bad_code(core_op)); // R11
endmodule

bind pbt_throttle pbt_checker #(.TCNT_W(TCNT_W), .BUD_W(BUD_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .thread_cnt(thread_cnt), .budget(budget),
  .vreg_ack(vreg_ack), .req_valid(req_valid), .req_cfg(req_cfg),
  .core_op(core_op), .busy(busy)
);

// File: tb/pbt_throttle_test.sv
module pbt_throttle_test;
  logic       clk = 1'b0;
  logic       rst_n;
  logic [2:0] thread_cnt;
  logic       dyn_mode;
  logic [4:0] budget;
  logic [7:0] settle_cycles;
  logic       vreg_ack;
  logic [3:0] core_en;
  logic [7:0] core_op;
  logic       busy;
  int n_chk = 0;
  int n_err = 0;

  always #10 clk = ~clk;

  pbt_throttle uut (
    .clk(clk), .rst_n(rst_n), .thread_cnt(thread_cnt), .dyn_mode(dyn_mode),
    .budget(budget), .settle_cycles(settle_cycles), .vreg_ack(vreg_ack),
    .core_en(core_en), .core_op(core_op), .busy(busy)
  );

  // {dyn_mode, thread_cnt, budget, expected core_op}
  localparam logic [16:0] VEC [0:13] = '{
    {1'b0, 3'd1, 5'd20, 8'h02},  // R2
    {1'b0, 3'd4, 5'd20, 8'h15},  // R3
    {1'b0, 3'd2, 5'd20, 8'h15},  // R3
    {1'b1, 3'd2, 5'd20, 8'h05},  // R4
    {1'b1, 3'd4, 5'd20, 8'h55},  // R4
    {1'b1, 3'd7, 5'd20, 8'h55},  // R4
    {1'b1, 3'd0, 5'd20, 8'h02},  // R2
    {1'b1, 3'd4, 5'd5,  8'h05},  // R5
    {1'b1, 3'd1, 5'd4,  8'h01},  // R5
    {1'b0, 3'd3, 5'd1,  8'h00},  // R5
    {1'b0, 3'd1, 5'd1,  8'h00},  // R5
    {1'b0, 3'd3, 5'd7,  8'h15},  // R5
    {1'b1, 3'd3, 5'd6,  8'h15},  // R5
    {1'b1, 3'd1, 5'd5,  8'h02}   // R2
  };

  function automatic logic [3:0] en_of(input logic [7:0] op);
    logic [3:0] e;
    for (int i = 0; i < 4; i++) e[i] = |op[2*i +: 2];
    return e;
  endfunction

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_err++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic ack_pulse();
    vreg_ack = 1'b1;
    cyc(1);
    vreg_ack = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog got=hung exp=done");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    rst_n = 1'b0; thread_cnt = 3'd0; dyn_mode = 1'b0; budget = 5'd20;
    settle_cycles = 8'd5; vreg_ack = 1'b0;
    cyc(3);
    rst_n = 1'b1;
    cyc(1);
    chk("R1 reset op", core_op, 8'h00);
    chk("R1 reset en", core_en, 4'h0);
    chk("R1 reset busy", busy, 1'b0);

    // table walk, settle of one extra cycle
    settle_cycles = 8'd1;
    for (int k = 0; k < 14; k++) begin
      {dyn_mode, thread_cnt, budget} = VEC[k][16:8];
      for (int w = 0; w < 12; w++) begin
        cyc(1);
        if (busy) break;
      end
      if (busy) ack_pulse();
      chk($sformatf("R2 R3 R4 R5 vector %0d op", k), core_op, VEC[k][7:0]);
      chk($sformatf("R11 vector %0d en", k), core_en, en_of(VEC[k][7:0]));
    end

    // R6 exact timing, settle 3: busy after 5 edges, not after 4
    budget = 5'd20; settle_cycles = 8'd3;
    cyc(4);
    dyn_mode = 1'b1; thread_cnt = 3'd4;
    cyc(4);
    chk("R6 busy not yet", busy, 1'b0);
    cyc(1);
    chk("R6 busy raised", busy, 1'b1);
    // R7 hold without ack
    cyc(5);
    chk("R7 hold op", core_op, 8'h02);
    chk("R7 still busy", busy, 1'b1);
    // R8 newer request replaces pending
    thread_cnt = 3'd2;
    cyc(7);
    chk("R8 hold before ack", core_op, 8'h02);
    ack_pulse();
    chk("R8 latest applied", core_op, 8'h05);
    chk("R8 busy cleared", busy, 1'b0);

    // R6 short excursion ignored
    thread_cnt = 3'd4;
    cyc(2);
    thread_cnt = 3'd2;
    cyc(10);
    chk("R6 glitch no busy", busy, 1'b0);
    chk("R6 glitch op", core_op, 8'h05);

    // R9 ack while idle
    ack_pulse();
    cyc(1);
    chk("R9 idle ack op", core_op, 8'h05);
    chk("R9 idle ack busy", busy, 1'b0);

    // R10 request and ack in one cycle, settle 2
    settle_cycles = 8'd2;
    thread_cnt = 3'd4;
    cyc(4);
    chk("R10 busy set", busy, 1'b1);
    thread_cnt = 3'd3;
    cyc(3);
    ack_pulse();
    chk("R10 newest op", core_op, 8'h15);
    chk("R10 busy low", busy, 1'b0);
    cyc(6);
    chk("R10 no spurious busy", busy, 1'b0);
    chk("R11 en after collision", core_en, 4'h7);

    // R1 reset while busy
    thread_cnt = 3'd1;
    cyc(4);
    chk("R7 busy before reset", busy, 1'b1);
    rst_n = 1'b0;
    cyc(1);
    chk("R1 mid reset op", core_op, 8'h00);
    chk("R1 mid reset busy", busy, 1'b0);
    rst_n = 1'b1;

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule